// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block holds the fetch address of a small pipelined processor with 16-bit instructions and 12-bit word addresses. Each time the pipeline fetches an instruction it raises the fetch enable, and the address moves on by one word. The processor has no flags register. A conditional branch therefore tests a general register for zero or nonzero and moves by a short signed offset relative to its own address. Unconditional jumps and jump-and-link carry a full 12-bit absolute target. Jump-register takes its target from a register.

A control instruction is resolved late, in the memory-access stage. Until it gets there the pipeline keeps fetch enable low. When it arrives, the pipeline raises the resolve strobe and presents the instruction's opcode, its low twelve bits, its own address and the value of the register it names. The register number itself is decoded outside this block. On the next clock edge the block loads the new fetch address. In the same cycle as the strobe, it offers the return address that a jump-and-link writes into the link register.

Top module: `pc_branch_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, the fetch address is 0.
- R2: With the strobe low and fetch enable high, the fetch address rises by one at the next clock edge. 4095 is followed by 0.
- R3: With both the strobe and fetch enable low, the fetch address does not change.
- R4: A strobe with opcode 1000 (unconditional jump) loads instruction bits 11:0 as the next fetch address.
- R5: A strobe with opcode 1001 (branch if zero) loads a new fetch address when the register value is all zeros. That address is the branch's own address plus instruction bits 8:0, sign-extended from bit 8, modulo 4096. Otherwise the next fetch address is the branch's own address plus one.
- R6: A strobe with opcode 1010 (branch if nonzero) takes the same offset when the register value is nonzero. Otherwise the next fetch address is the branch's own address plus one.
- R7: A strobe with opcode 1100 (jump-and-link) loads instruction bits 11:0 as the next fetch address. In the same cycle it raises the link write and drives the link data with the branch's own address plus one, modulo 4096, zero-extended to 16 bits. The link write is low for every other strobe.
- R8: A strobe with opcode 1111 and instruction bits 3:0 equal to 0000 (jump-register) loads the low 12 bits of the register value as the next fetch address.
- R9: When the strobe and fetch enable are high together, the strobe decides the next address.
- R10: A strobe carrying any other opcode, including 1111 with nonzero bits 3:0, redirects nothing. The fetch address then follows fetch enable as in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_en | input | 1 | An instruction is fetched this cycle |
| res_valid | input | 1 | A control instruction resolves this cycle |
| res_op | input | 4 | Opcode (instruction bits 15:12) of the resolving instruction |
| res_field | input | 12 | Instruction bits 11:0 of the resolving instruction |
| res_pc | input | 12 | Address of the resolving instruction |
| res_reg | input | 16 | Value of the register the instruction names |
| fetch_addr | output | 12 | Current fetch address |
| link_we | output | 1 | Jump-and-link writes the link register this cycle |
| link_data | output | 16 | Return address to write |

## Verification
The fetch address is a single register. Every redirect, step and hold is therefore due one clock edge after the inputs that cause it. The bench drives the inputs on the falling edge and reads the fetch address one nanosecond after the next rising edge. The link write and link data are combinational. They are read in the same cycle as the strobe, before the rising edge, and the inputs are returned to idle afterwards. Each task knows the address before its stimulus, so it can predict the exact value after that single edge. This covers offsets that wrap past 4095 in either direction.

// File: rtl/pc_branch_unit.sv
module pc_branch_unit #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int OFF_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_en,
  input  logic              res_valid,
  input  logic [3:0]        res_op,
  input  logic [ADDR_W-1:0] res_field,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic [DATA_W-1:0] res_reg,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              link_we,
  output logic [DATA_W-1:0] link_data
);

  localparam logic [3:0] OP_JMP  = 4'b1000;
  localparam logic [3:0] OP_BZ   = 4'b1001;
  localparam logic [3:0] OP_BNZ  = 4'b1010;
  localparam logic [3:0] OP_JAL  = 4'b1100;
  localparam logic [3:0] OP_REG  = 4'b1111;

  logic [ADDR_W-1:0] pc_q, pc_d, seq_pc, rel_pc, offset;
  logic              reg_zero, redirect;

  assign seq_pc   = res_pc + ADDR_W'(1);
  assign offset   = {{(ADDR_W-OFF_W){res_field[OFF_W-1]}}, res_field[OFF_W-1:0]};
  assign rel_pc   = res_pc + offset;
  assign reg_zero = (res_reg == '0);

  always_comb begin
    redirect = 1'b1;
    pc_d     = fetch_en ? pc_q + ADDR_W'(1) : pc_q;
    unique case (res_op)
      OP_JMP, OP_JAL: pc_d = res_field;
      OP_BZ:          pc_d = reg_zero ? rel_pc : seq_pc;
      OP_BNZ:         pc_d = reg_zero ? seq_pc : rel_pc;
      OP_REG:         if (res_field[3:0] == 4'b0000) pc_d = res_reg[ADDR_W-1:0];
                      else redirect = 1'b0;
      default:        redirect = 1'b0;
    endcase
    if (!res_valid || !redirect)
      pc_d = fetch_en ? pc_q + ADDR_W'(1) : pc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign fetch_addr = pc_q;
  assign link_we    = res_valid && (res_op == OP_JAL);
  assign link_data  = {{(DATA_W-ADDR_W){1'b0}}, seq_pc};

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && !fetch_en) |=> $stable(fetch_addr)); // R3

  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && fetch_en) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1)); // R2

  AST_ABS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_op == OP_JMP || res_op == OP_JAL)) |=> fetch_addr == $past(res_field)); // R4

  AST_REG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_op == OP_REG && res_field[3:0] == 4'b0000)
      |=> fetch_addr == $past(res_reg[ADDR_W-1:0])); // R8

  AST_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_op[3] == 1'b0 && !fetch_en) |=> $stable(fetch_addr)); // R10

endmodule

// File: tb/pc_branch_unit_tb.sv
module pc_branch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, fetch_en, res_valid;
  logic [3:0]  res_op;
  logic [11:0] res_field, res_pc, fetch_addr;
  logic [15:0] res_reg, link_data;
  logic        link_we;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pc_branch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .res_valid(res_valid),
    .res_op(res_op), .res_field(res_field), .res_pc(res_pc), .res_reg(res_reg),
    .fetch_addr(fetch_addr), .link_we(link_we), .link_data(link_data)
  );

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    fetch_en = 0; res_valid = 0; res_op = 4'h0; res_field = '0; res_pc = '0; res_reg = '0;
  endtask

  task automatic step(bit v, logic [3:0] op, logic [11:0] f, logic [11:0] bpc,
                      logic [15:0] r, bit fe);
    @(negedge clk);
    res_valid = v; res_op = op; res_field = f; res_pc = bpc; res_reg = r; fetch_en = fe;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic t_reset();
    idle(); rst_n = 0;
    repeat (3) @(posedge clk);
    #1 chk("R1 in reset", {4'h0, fetch_addr}, 16'h0000);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1 chk("R1 after release", {4'h0, fetch_addr}, 16'h0000);
  endtask

  task automatic t_step_hold();
    for (int i = 0; i < 3; i++) step(0, 4'h0, '0, '0, '0, 1);
    chk("R2 step", {4'h0, fetch_addr}, 16'h0003);
    step(0, 4'h0, '0, '0, '0, 0);
    step(0, 4'h0, '0, '0, '0, 0);
    chk("R3 hold", {4'h0, fetch_addr}, 16'h0003);
  endtask

  task automatic t_jump_wrap();
    step(1, 4'b1000, 12'hA5C, 12'h003, 16'h0, 0);
    chk("R4 jump", {4'h0, fetch_addr}, 16'h0A5C);
    step(1, 4'b1000, 12'hFFF, 12'hA5C, 16'h0, 0);
    step(0, 4'h0, '0, '0, '0, 1);
    chk("R2 wrap", {4'h0, fetch_addr}, 16'h0000);
  endtask

  task automatic t_bz();
    step(1, 4'b1001, 12'h1FD, 12'h100, 16'h0000, 0);
    chk("R5 taken back", {4'h0, fetch_addr}, 16'h00FD);
    step(1, 4'b1001, 12'h1FD, 12'h100, 16'h0005, 0);
    chk("R5 not taken", {4'h0, fetch_addr}, 16'h0101);
    step(1, 4'b1001, 12'h005, 12'hFFE, 16'h0000, 0);
    chk("R5 taken wrap", {4'h0, fetch_addr}, 16'h0003);
  endtask

  task automatic t_bnz();
    step(1, 4'b1010, 12'h0FF, 12'h010, 16'h8000, 0);
    chk("R6 taken", {4'h0, fetch_addr}, 16'h010F);
    step(1, 4'b1010, 12'h0FF, 12'h010, 16'h0000, 0);
    chk("R6 not taken", {4'h0, fetch_addr}, 16'h0011);
  endtask

  task automatic t_jal();
    @(negedge clk);
    res_valid = 1; res_op = 4'b1100; res_field = 12'h800; res_pc = 12'h234; res_reg = '0;
    #1 chk("R7 link we", {15'h0, link_we}, 16'h0001);
    chk("R7 link data", link_data, 16'h0235);
    @(posedge clk); #1 chk("R7 target", {4'h0, fetch_addr}, 16'h0800);
    idle();
    @(negedge clk);
    res_valid = 1; res_op = 4'b1100; res_field = 12'h010; res_pc = 12'hFFF;
    #1 chk("R7 link wrap", link_data, 16'h0000);
    @(posedge clk); #1 idle();
    @(negedge clk);
    res_valid = 1; res_op = 4'b1000; res_field = 12'h010;
    #1 chk("R7 no link on jump", {15'h0, link_we}, 16'h0000);
    @(posedge clk); #1 idle();
  endtask

  task automatic t_jr();
    step(1, 4'b1111, 12'hE70, 12'h010, 16'hF3C7, 0);
    chk("R8 jump register", {4'h0, fetch_addr}, 16'h03C7);
    @(negedge clk);
    res_valid = 1; res_op = 4'b1111; res_field = 12'hE71; res_reg = 16'h0123;
    #1 chk("R10 no link on reg op", {15'h0, link_we}, 16'h0000);
    @(posedge clk); #1 idle();
    chk("R10 reg op ignored", {4'h0, fetch_addr}, 16'h03C7);
  endtask

  task automatic t_priority();
    step(1, 4'b1000, 12'h123, 12'h3C7, 16'h0, 1);
    chk("R9 strobe wins", {4'h0, fetch_addr}, 16'h0123);
    step(1, 4'b0100, 12'hFFF, 12'h555, 16'h0, 1);
    chk("R10 non-branch steps", {4'h0, fetch_addr}, 16'h0124);
    step(1, 4'b0000, 12'h0AA, 12'h555, 16'h0, 0);
    chk("R10 non-branch holds", {4'h0, fetch_addr}, 16'h0124);
  endtask

  initial begin
    t_reset();
    t_step_hold();
    t_jump_wrap();
    t_bz();
    t_bnz();
    t_jal();
    t_jr();
    t_priority();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (R1..all): actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule